// File: doc/BRIEF.md
# Spread-Spectrum Divider Ratio Modulator

This block sweeps the ratio fed to each of four fractional output dividers along a triangular profile, so that each bank's output frequency is spread over a small band and its EMI peak drops. Each bank has its own nominal ratio, a spread amount code, and a mode bit. In down mode the ratio only rises above nominal, so the frequency only falls. In center mode the ratio swings evenly about nominal. A shared exponent sets the sweep period. Each bank has an enable bit, and one global kill input switches spreading off for every bank whatever those bits hold.

The triangle is made by a position counter and an offset accumulator per bank. Each clock, the accumulator adds or subtracts the bank's peak deviation, and the direction reverses at either end of the sweep. The visible offset is the accumulator shifted right by the period exponent, which removes any divider. Mode, amount and exponent are captured when a bank starts spreading. The nominal ratio is used live. A bank that is spreading raises its phase-adjust inhibit flag.

Top module: `ss_ratio_modulator`

## Requirements
- R1: A bank whose enable bit is 0 outputs exactly its nominal ratio.
- R2: While the global kill input is 1, every bank outputs its nominal ratio and every inhibit flag is 0, whatever the enable bits hold.
- R3: The inhibit flag of bank b is 1 exactly when its enable bit is 1 and the kill input is 0.
- R4: Down mode (mode bit 0). The output is nominal + floor(D·p/H), where D = floor(nominal·c/1024), c is the amount code, H = 2^e, and p is the sweep position, which is 0 in the first cycle of spreading.
- R5: Center mode (mode bit 1). The output is nominal − floor(D/2) + floor(D·p/H). The sweep position starts at H/2, so the first spreading cycle outputs exactly the nominal ratio.
- R6: The sweep position changes by one each clock. It rises to H, falls to 0, then rises again, so a full sweep takes 2^(e+1) clocks. An exponent of 0 is treated as 1.
- R7: An amount code above 51 is treated as 51, which is about 5 %.
- R8: Amount, mode and exponent are taken when a bank starts spreading. Changing them while the bank is spreading has no effect on its output until spreading restarts. The nominal ratio is always used live.
- R9: When a bank is disabled and then re-enabled, its sweep restarts from the nominal ratio at the start position.
- R10: While reset is low, every bank outputs its nominal ratio, and no bank is spreading on the first cycle after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock; one sweep tick per rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| nominal_i | input | BANKS*NW | Nominal divider ratio per bank, bank 0 in the low bits |
| amount_i | input | BANKS*AW | Spread amount code per bank, in units of 1/1024 |
| mode_i | input | BANKS | Per-bank mode: 0 down, 1 center |
| span_exp_i | input | PW | Half-sweep length exponent e (H = 2^e clocks) |
| bank_en_i | input | BANKS | Per-bank spread enable |
| spread_kill_i | input | 1 | Global spread disable, overrides the enables |
| ratio_o | output | BANKS*(NW+1) | Instantaneous divider ratio per bank |
| phase_inhibit_o | output | BANKS | Per-bank phase-adjust inhibit |

## Verification
The assertions assume that each nominal ratio is large enough for the center-mode low point, nominal − D/2, to stay at or above zero. At the permitted spread amounts this holds for any nonzero nominal, and the random stimulus draws nominals in the upper part of the range. The sweep-position checks assume a settled exponent when spreading starts. The stimulus changes configuration only between clock edges, and it draws exponents from a small range so that many full sweeps, turnarounds and restarts occur. Directed cases cover the clamped amount code, the zero exponent, changes made while spreading, and global kill with every bank enabled.

// File: rtl/sweep_pkg.sv
// sweep_pkg: constants and types shared by the spread modulator.
// Assumes amount codes are in units of 1/1024 of the nominal ratio.
package sweep_pkg;
    localparam int AMT_SHIFT = 10;   // amount code denominator is 2^AMT_SHIFT
    localparam int AMT_CAP   = 51;   // largest usable code, about 5 %

    typedef enum logic {
        SPREAD_DOWN   = 1'b0,
        SPREAD_CENTER = 1'b1
    } spread_mode_e;
endpackage

// File: rtl/sweep_depth.sv
// sweep_depth: peak ratio deviation D = floor(nominal * code / 1024),
// with the code saturated at AMT_CAP. Purely combinational.
// Assumes AW is wide enough to hold AMT_CAP.
module sweep_depth
    import sweep_pkg::*;
#(
    parameter int NW = 24,
    parameter int AW = 6
) (
    input  logic [NW-1:0] nom_i,
    input  logic [AW-1:0] amt_i,
    output logic [NW-1:0] depth_o
);
    localparam int PRW = NW + AW;

    logic [AW-1:0]  code;
    logic [PRW-1:0] prod;

    // Saturate the amount code at the largest permitted spread.
    always_comb code = (int'(amt_i) > AMT_CAP) ? AW'(AMT_CAP) : amt_i;

    // Scale the nominal ratio by the code and drop the fraction bits.
    always_comb begin
        prod    = PRW'(nom_i) * PRW'(code);
        depth_o = NW'(prod >> AMT_SHIFT);
    end
endmodule

// File: rtl/sweep_lane.sv
// sweep_lane: triangle generator for one bank. A position counter walks
// 0..H..0 (H = 2^e) while an accumulator tracks D*position. The visible
// offset is the accumulator shifted right by e. Depth, mode and exponent
// are latched when run_i first rises. Assumes nom_i >= depth_i/2.
module sweep_lane #(
    parameter int NW = 24,
    parameter int PW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run_i,
    input  logic [NW-1:0] nom_i,
    input  logic [NW-1:0] depth_i,
    input  logic          center_i,
    input  logic [PW-1:0] exp_i,
    output logic [NW:0]   ratio_o
);
    localparam int KMAX = (1 << PW) - 1;
    localparam int PSW  = KMAX + 1;
    localparam int ACW  = NW + KMAX;

    logic          act_q, up_q, center_q;
    logic [PSW-1:0] pos_q;
    logic [ACW-1:0] acc_q;
    logic [NW-1:0]  depth_q;
    logic [PW-1:0]  exp_q;

    logic [PW-1:0]  exp_eff;
    logic [PSW-1:0] span, start_pos;
    logic [ACW-1:0] start_acc;
    logic [NW-1:0]  offset;

    // Clamp a zero exponent to one so the center start point exists.
    always_comb exp_eff = (exp_i == '0) ? PW'(1) : exp_i;

    // Start position and accumulator value for the mode about to be latched.
    always_comb begin
        start_pos = center_i ? (PSW'(1) << (exp_eff - PW'(1))) : '0;
        start_acc = center_i ? (ACW'(depth_i) << (exp_eff - PW'(1))) : '0;
    end

    // Half-sweep length of the latched configuration.
    always_comb span = PSW'(1) << exp_q;

    // Sweep state: restart on activation, then step and turn at the ends.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q    <= 1'b0;
            up_q     <= 1'b1;
            pos_q    <= '0;
            acc_q    <= '0;
            depth_q  <= '0;
            exp_q    <= PW'(1);
            center_q <= 1'b0;
        end else if (!run_i) begin
            act_q <= 1'b0;
        end else if (!act_q) begin
            act_q    <= 1'b1;
            up_q     <= 1'b1;
            pos_q    <= start_pos;
            acc_q    <= start_acc;
            depth_q  <= depth_i;
            exp_q    <= exp_eff;
            center_q <= center_i;
        end else if (up_q) begin
            pos_q <= pos_q + PSW'(1);
            acc_q <= acc_q + ACW'(depth_q);
            if (pos_q == span - PSW'(1)) up_q <= 1'b0;
        end else begin
            pos_q <= pos_q - PSW'(1);
            acc_q <= acc_q - ACW'(depth_q);
            if (pos_q == PSW'(1)) up_q <= 1'b1;
        end
    end

    // Visible offset: D*position scaled down by the half-sweep length.
    always_comb offset = NW'(acc_q >> exp_q);

    // Output ratio: nominal when idle, else nominal plus the profile.
    always_comb begin
        if (run_i && act_q) begin
            if (center_q)
                ratio_o = {1'b0, nom_i} + {1'b0, offset} - {2'b0, depth_q[NW-1:1]};
            else
                ratio_o = {1'b0, nom_i} + {1'b0, offset};
        end else begin
            ratio_o = {1'b0, nom_i};
        end
    end

    // R6
    pos_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        act_q |-> (pos_q <= span));

    // R6
    pos_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (act_q && $past(act_q)) |->
            ((pos_q == $past(pos_q) + PSW'(1)) || (pos_q == $past(pos_q) - PSW'(1))));

    // R8
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (act_q && $past(act_q)) |->
            ($stable(depth_q) && $stable(exp_q) && $stable(center_q)));

    // R4
    down_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (act_q && run_i && !center_q) |->
            ((ratio_o >= {1'b0, nom_i}) && (ratio_o <= {1'b0, nom_i} + {1'b0, depth_q})));

    // R5
    start_nominal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(act_q) && run_i) |-> (ratio_o == {1'b0, nom_i}));
endmodule

// File: rtl/ss_ratio_modulator.sv
// ss_ratio_modulator: four-bank (BANKS) spread-spectrum ratio modulator.
// Each bank gets a depth calculator and a triangle lane. The global kill
// input overrides the per-bank enables. Inputs are packed, bank 0 lowest.
// Assumes inputs change away from the clock edge.
module ss_ratio_modulator
    import sweep_pkg::*;
#(
    parameter int BANKS = 4,
    parameter int NW    = 24,
    parameter int AW    = 6,
    parameter int PW    = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [BANKS*NW-1:0]   nominal_i,
    input  logic [BANKS*AW-1:0]   amount_i,
    input  logic [BANKS-1:0]      mode_i,
    input  logic [PW-1:0]         span_exp_i,
    input  logic [BANKS-1:0]      bank_en_i,
    input  logic                  spread_kill_i,
    output logic [BANKS*(NW+1)-1:0] ratio_o,
    output logic [BANKS-1:0]      phase_inhibit_o
);
    localparam int RW = NW + 1;

    logic [BANKS-1:0] run;

    // Per-bank effective enable: the global kill wins over the bank bit.
    always_comb run = bank_en_i & {BANKS{~spread_kill_i}};

    // A bank that spreads cannot take phase adjustment.
    always_comb phase_inhibit_o = run;

    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        logic [NW-1:0] depth;
        logic [RW-1:0] ratio;

        sweep_depth #(.NW(NW), .AW(AW)) u_depth (
            .nom_i   (nominal_i[b*NW +: NW]),
            .amt_i   (amount_i[b*AW +: AW]),
            .depth_o (depth)
        );

        sweep_lane #(.NW(NW), .PW(PW)) u_lane (
            .clk      (clk),
            .rst_n    (rst_n),
            .run_i    (run[b]),
            .nom_i    (nominal_i[b*NW +: NW]),
            .depth_i  (depth),
            .center_i (spread_mode_e'(mode_i[b]) == SPREAD_CENTER),
            .exp_i    (span_exp_i),
            .ratio_o  (ratio)
        );

        assign ratio_o[b*RW +: RW] = ratio;

        // R1
        idle_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !phase_inhibit_o[b] |-> (ratio_o[b*RW +: RW] == {1'b0, nominal_i[b*NW +: NW]}));
    end

    // R2
    kill_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        spread_kill_i |-> (phase_inhibit_o == '0));
endmodule

// File: tb/sim_ss_ratio_modulator.sv
`timescale 1ns/1ps
module sim_ss_ratio_modulator;
    localparam int BANKS = 4;
    localparam int NW    = 24;
    localparam int AW    = 6;
    localparam int PW    = 4;
    localparam int RW    = NW + 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [BANKS*NW-1:0] nominal_i = '0;
    logic [BANKS*AW-1:0] amount_i = '0;
    logic [BANKS-1:0]    mode_i = '0;
    logic [PW-1:0]       span_exp_i = PW'(1);
    logic [BANKS-1:0]    bank_en_i = '0;
    logic                spread_kill_i = 1'b0;
    logic [BANKS*RW-1:0] ratio_o;
    logic [BANKS-1:0]    phase_inhibit_o;

    ss_ratio_modulator #(.BANKS(BANKS), .NW(NW), .AW(AW), .PW(PW)) u0 (
        .clk(clk), .rst_n(rst_n), .nominal_i(nominal_i), .amount_i(amount_i),
        .mode_i(mode_i), .span_exp_i(span_exp_i), .bank_en_i(bank_en_i),
        .spread_kill_i(spread_kill_i), .ratio_o(ratio_o),
        .phase_inhibit_o(phase_inhibit_o)
    );

    always #2 clk = ~clk;

    int vectors = 0;
    int errors  = 0;
    bit finished = 0;
    string tag_ovr = "";

    // Reference model state, one entry per bank.
    bit      m_act[BANKS];
    bit      m_up[BANKS];
    bit      m_cen[BANKS];
    longint  m_p[BANKS];
    longint  m_d[BANKS];
    int      m_k[BANKS];

    function automatic longint nom_of(int b);
        return longint'(nominal_i[b*NW +: NW]);
    endfunction

    function automatic bit run_of(int b);
        return bank_en_i[b] && !spread_kill_i;
    endfunction

    // Expected ratio from R1, R2, R4, R5 given model state and current inputs.
    function automatic longint exp_ratio(int b);
        longint off;
        if (!(rst_n && run_of(b) && m_act[b])) return nom_of(b);
        off = (m_d[b] * m_p[b]) >> m_k[b];
        if (m_cen[b]) return nom_of(b) - (m_d[b] >> 1) + off;
        return nom_of(b) + off;
    endfunction

    // Advance the model over one rising edge (R6, R7, R8, R9, R10).
    task automatic model_edge();
        for (int b = 0; b < BANKS; b++) begin
            if (!rst_n || !run_of(b)) begin
                m_act[b] = 0;
            end else if (!m_act[b]) begin
                int c;
                int e;
                c = int'(amount_i[b*AW +: AW]);
                if (c > 51) c = 51;
                e = int'(span_exp_i);
                if (e == 0) e = 1;
                m_act[b] = 1;
                m_d[b]   = (nom_of(b) * longint'(c)) >> 10;
                m_k[b]   = e;
                m_cen[b] = mode_i[b];
                m_p[b]   = mode_i[b] ? (longint'(1) << (e - 1)) : 0;
                m_up[b]  = 1;
            end else if (m_up[b]) begin
                m_p[b]++;
                if (m_p[b] == (longint'(1) << m_k[b])) m_up[b] = 0;
            end else begin
                m_p[b]--;
                if (m_p[b] == 0) m_up[b] = 1;
            end
        end
    endtask

    // Compare every bank's outputs with the model.
    task automatic check_all();
        for (int b = 0; b < BANKS; b++) begin
            longint got, want;
            string t;
            bit want_inh;
            got  = longint'(ratio_o[b*RW +: RW]);
            want = exp_ratio(b);
            if (tag_ovr != "") t = tag_ovr;
            else if (!rst_n) t = "R10";
            else if (spread_kill_i) t = "R2";
            else if (!bank_en_i[b]) t = "R1";
            else if (m_cen[b] && m_act[b]) t = "R5";
            else t = "R4";
            vectors++;
            if (got != want) begin
                errors++;
                $display("FAIL %s bank %0d ratio: got %0d expected %0d", t, b, got, want);
            end
            want_inh = run_of(b);
            vectors++;
            if (phase_inhibit_o[b] !== want_inh) begin
                errors++;
                $display("FAIL R3 bank %0d inhibit: got %0b expected %0b",
                         b, phase_inhibit_o[b], want_inh);
            end
        end
    endtask

    // One cycle: inputs already set after a falling edge; check, model, advance.
    task automatic cycle(int n = 1);
        for (int i = 0; i < n; i++) begin
            #1;
            check_all();
            model_edge();
            @(negedge clk);
        end
    endtask

    task automatic set_bank(int b, longint nom, int amt, bit cen);
        nominal_i[b*NW +: NW] = NW'(nom);
        amount_i[b*AW +: AW]  = AW'(amt);
        mode_i[b]             = cen;
    endtask

    initial begin
        for (int b = 0; b < BANKS; b++) begin
            m_act[b] = 0; m_up[b] = 1; m_cen[b] = 0; m_p[b] = 0; m_d[b] = 0; m_k[b] = 1;
        end
        void'($urandom(32'h5EED_0042));
        @(negedge clk);

        // R10: reset held with every bank enabled.
        set_bank(0, 1000000, 20, 0);
        set_bank(1, 2000000, 30, 1);
        set_bank(2, 3000000, 51, 0);
        set_bank(3, 4000000, 10, 1);
        span_exp_i = PW'(2);
        bank_en_i  = '1;
        tag_ovr = "R10";
        cycle(3);
        rst_n = 1'b1;
        cycle(1);
        tag_ovr = "";
        cycle(20);

        // R7: amount code above the cap.
        bank_en_i = '0;
        cycle(1);
        set_bank(0, 1000000, 63, 0);
        set_bank(1, 1000000, 51, 1);
        bank_en_i = 4'b0011;
        tag_ovr = "R7";
        cycle(12);

        // R6: zero exponent behaves as one; full sweeps of several lengths.
        bank_en_i = '0;
        cycle(1);
        span_exp_i = '0;
        bank_en_i = '1;
        tag_ovr = "R6";
        cycle(10);
        bank_en_i = '0;
        cycle(1);
        span_exp_i = PW'(3);
        bank_en_i = '1;
        cycle(40);

        // R8: change amount, mode and exponent while spreading.
        tag_ovr = "R8";
        for (int b = 0; b < BANKS; b++) begin
            amount_i[b*AW +: AW] = AW'(5);
            mode_i[b] = ~mode_i[b];
        end
        span_exp_i = PW'(1);
        cycle(20);

        // R9: drop one bank for a cycle, re-enable, sweep restarts.
        tag_ovr = "R9";
        bank_en_i[2] = 1'b0;
        cycle(1);
        bank_en_i[2] = 1'b1;
        cycle(10);

        // R2: global kill with every bank enabled.
        tag_ovr = "R2";
        spread_kill_i = 1'b1;
        cycle(5);
        spread_kill_i = 1'b0;
        tag_ovr = "";
        cycle(10);

        // Constrained random mix.
        for (int i = 0; i < 6000; i++) begin
            int r;
            r = int'($urandom_range(0, 99));
            if (r < 4) bank_en_i[$urandom_range(0, BANKS-1)] ^= 1'b1;
            else if (r < 5) spread_kill_i = ~spread_kill_i;
            else if (r < 9) begin
                set_bank(int'($urandom_range(0, BANKS-1)),
                         longint'($urandom_range(24'h10_0000, 24'hFF_FFFF)),
                         int'($urandom_range(0, 63)), 1'($urandom_range(0, 1)));
            end else if (r < 10) span_exp_i = PW'($urandom_range(0, 5));
            cycle(1);
        end

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(4 * 150000);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end
endmodule